// File: doc/BRIEF.md
# Multi-Mode Program ROM Bank Mapper

This block turns a CPU address in the upper 40 KB of the address space (0x6000 to 0xFFFF) into the number of an 8 KB program ROM bank. Software programs four 8-bit bank registers and two control registers through ordinary CPU writes. A three-bit mode field picks one of eight layouts. These layouts split the 0x8000 to 0xFFFF area into one 32 KB bank, two 16 KB banks or four 8 KB banks. In each layout the topmost bank is either fixed or taken from the fourth bank register.

An optional window at 0x6000 to 0x7FFF can also be backed by ROM. Its 8 KB bank comes from the fourth bank register, scaled to suit the active granularity. A two-bit outer block select is placed above every bank number, so one 512 KB block out of four can be chosen.

The output is always given in 8 KB units. For larger granularities, the missing low bank bits come from the CPU address. Register writes take effect on the next clock edge. The translation path is purely combinational.

Top module: `prgmap_top`

## Requirements
- R1: After reset every bank register holds 0xFF, the mode field is 0, the window is disabled and the outer block is 0, so 0x8000 maps to bank 0x3C and 0xE000 to bank 0x3F.
- R2: A write with address bits [15:12] = 0x8 loads bank register number addr[1:0]. Bits [15:12] = 0xD with addr[1:0] = 0 loads control A (bits [2:0] mode, bit 7 window enable). With addr[1:0] = 3 it loads control B (bits [2:1] outer block). All other writes change nothing. A write is visible one cycle after it is taken.
- R3: Mode 0 maps the 32 KB area 0x8000 to 0xFFFF to inner 32 KB bank 0x0F, which gives 8 KB bank {0x0F, addr[14:13]}.
- R4: Mode 4 maps the 32 KB area to inner 32 KB bank reg3[3:0].
- R5: Mode 1 maps reg1[4:0] as a 16 KB bank at 0x8000 and a fixed 0x1F at 0xC000. The 8 KB bank is {bank16, addr[13]}.
- R6: Mode 5 is mode 1 with reg3[4:0] as the 16 KB bank at 0xC000.
- R7: Modes 2 and 3 map reg0, reg1 and reg2 (low 6 bits) at 0x8000, 0xA000 and 0xC000, with a fixed 0x3F at 0xE000.
- R8: Modes 6 and 7 are modes 2 and 3 with reg3[5:0] at 0xE000.
- R9: When control A bit 7 is set, 0x6000 to 0x7FFF is ROM and `win_hit` is 1. The inner bank is (reg3*4+3) in the 32 KB modes (mode[1:0]=0), (reg3*2+1) in the 16 KB modes (mode[1:0]=1), and reg3 in the 8 KB modes. In every case it is kept to 6 bits.
- R10: Every mapped bank number carries the outer block in bits [7:6] above the 6-bit inner bank.
- R11: Addresses below 0x6000, and the window area while it is disabled, give `rom_sel` = 0, `win_hit` = 0 and `bank_out` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | CPU write strobe, one cycle per write |
| wr_addr | input | 16 | CPU write address |
| wr_data | input | 8 | CPU write data |
| cpu_addr | input | 16 | CPU address to translate |
| bank_out | output | 8 | 8 KB ROM bank number, outer block in [7:6] |
| rom_sel | output | 1 | Address is backed by ROM |
| win_hit | output | 1 | Address falls in the enabled 0x6000 window |

## Verification
The bench builds the block with its default parameters: four 8-bit bank registers, a 16-bit address, a 2-bit outer select and a 6-bit inner bank. With these values all eight modes, the three window scalings and all four outer blocks can be reached. Register values of 0xFF make the 6-bit masking of the window bank visible at its limit. Writes to decoded-but-unused or foreign addresses are checked against later translations to show that they have no effect.

// File: rtl/prgmap_pkg.sv
`timescale 1ns/1ps
package prgmap_pkg;
  typedef enum logic [1:0] {
    GR_32K = 2'd0,
    GR_16K = 2'd1,
    GR_8K  = 2'd2
  } grain_e;

  // Mode bits [1:0] choose the slot size; bit 2 makes the top slot switchable
  function automatic grain_e grain_of(input logic [2:0] mode);
    case (mode[1:0])
      2'd0:    grain_of = GR_32K;
      2'd1:    grain_of = GR_16K;
      default: grain_of = GR_8K;
    endcase
  endfunction
endpackage

// File: rtl/prgmap_regs.sv
`timescale 1ns/1ps
module prgmap_regs #(
  parameter int NUM_BANK  = 4,
  parameter int DATA_W    = 8,
  parameter int ADDR_W    = 16,
  parameter int OUTER_W   = 2,
  parameter logic [3:0] BANK_PAGE = 4'h8,
  parameter logic [3:0] CTRL_PAGE = 4'hD
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              wr_en,
  input  logic [ADDR_W-1:0]                 wr_addr,
  input  logic [DATA_W-1:0]                 wr_data,
  output logic [NUM_BANK-1:0][DATA_W-1:0]   bank_q,
  output logic [2:0]                        mode_q,
  output logic                              win_en_q,
  output logic [OUTER_W-1:0]                outer_q
);
  localparam int SEL_W = $clog2(NUM_BANK);
  localparam logic [SEL_W-1:0] CTRL_A_SEL = '0;
  localparam logic [SEL_W-1:0] CTRL_B_SEL = SEL_W'(NUM_BANK - 1);

  logic             page_bank, page_ctrl;
  logic [SEL_W-1:0] sel;
  logic             ctrl_a_we, ctrl_b_we;
  logic [2:0]         mode_d;
  logic               win_en_d;
  logic [OUTER_W-1:0] outer_d;
  logic unused_addr;

  assign page_bank = wr_en && (wr_addr[ADDR_W-1 -: 4] == BANK_PAGE);
  assign page_ctrl = wr_en && (wr_addr[ADDR_W-1 -: 4] == CTRL_PAGE);
  assign sel       = wr_addr[SEL_W-1:0];
  assign ctrl_a_we = page_ctrl && (sel == CTRL_A_SEL);
  assign ctrl_b_we = page_ctrl && (sel == CTRL_B_SEL);
  assign unused_addr = ^wr_addr[ADDR_W-5:SEL_W];

  // Bank register storage, one enabled register per entry
  for (genvar g = 0; g < NUM_BANK; g++) begin : g_bank
    logic              we;
    logic [DATA_W-1:0] d;
    always_comb begin
      we = page_bank && (sel == SEL_W'(g));
      d  = we ? wr_data : bank_q[g];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  bank_q[g] <= '1;
      else if (we) bank_q[g] <= d;
    end
  end

  // Control field next state
  always_comb begin
    mode_d   = mode_q;
    win_en_d = win_en_q;
    outer_d  = outer_q;
    if (ctrl_a_we) begin
      mode_d   = wr_data[2:0];
      win_en_d = wr_data[DATA_W-1];
    end
    if (ctrl_b_we) outer_d = wr_data[OUTER_W:1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= '0;
      win_en_q <= 1'b0;
    end else if (ctrl_a_we) begin
      mode_q   <= mode_d;
      win_en_q <= win_en_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         outer_q <= '0;
    else if (ctrl_b_we) outer_q <= outer_d;
  end

  // R2: a taken bank write is visible on the next cycle
  a_r2_bank_write: assert property (@(posedge clk) disable iff (!rst_n)
    page_bank |=> bank_q[$past(sel)] == $past(wr_data));

  // R2: control fields move only on their own write
  a_r2_ctrl_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_a_we |=> $stable(mode_q) && $stable(win_en_q));

  a_r2_outer_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_b_we |=> $stable(outer_q));
endmodule

// File: rtl/prgmap_xlate.sv
`timescale 1ns/1ps
module prgmap_xlate
  import prgmap_pkg::*;
#(
  parameter int NUM_BANK = 4,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int OUTER_W  = 2,
  parameter int INNER_W  = 6
) (
  input  logic [ADDR_W-1:0]               cpu_addr,
  input  logic [NUM_BANK-1:0][DATA_W-1:0] bank_q,
  input  logic [2:0]                      mode,
  input  logic                            win_en,
  input  logic [OUTER_W-1:0]              outer,
  output logic [OUTER_W+INNER_W-1:0]      bank_out,
  output logic                            rom_sel,
  output logic                            win_hit
);
  localparam int W16  = INNER_W - 1;
  localparam int W32  = INNER_W - 2;
  localparam int LAST = NUM_BANK - 1;
  localparam logic [2:0] WIN_SLOT = 3'd3;

  grain_e             grain;
  logic [2:0]         slot;
  logic               sw_last;
  logic [W32-1:0]     b32;
  logic [W16-1:0]     b16;
  logic [INNER_W-1:0] main_inner, win_inner, inner;
  logic               in_main;
  logic unused_bits;

  assign grain   = grain_of(mode);
  assign slot    = cpu_addr[ADDR_W-1 -: 3];
  assign sw_last = mode[2];
  assign in_main = slot[2];
  assign unused_bits = ^{cpu_addr[ADDR_W-4:0], bank_q[0][DATA_W-1:INNER_W],
                         bank_q[1][DATA_W-1:INNER_W], bank_q[2][DATA_W-1:INNER_W],
                         bank_q[LAST][DATA_W-1:INNER_W]};

  // Main area 0x8000-0xFFFF
  always_comb begin
    b32 = sw_last ? bank_q[LAST][W32-1:0] : '1;
    b16 = cpu_addr[ADDR_W-2] ? (sw_last ? bank_q[LAST][W16-1:0] : '1)
                             : bank_q[1][W16-1:0];
    case (grain)
      GR_32K:  main_inner = {b32, cpu_addr[ADDR_W-2:ADDR_W-3]};
      GR_16K:  main_inner = {b16, cpu_addr[ADDR_W-3]};
      default: begin
        case (slot[1:0])
          2'd0:    main_inner = bank_q[0][INNER_W-1:0];
          2'd1:    main_inner = bank_q[1][INNER_W-1:0];
          2'd2:    main_inner = bank_q[2][INNER_W-1:0];
          default: main_inner = sw_last ? bank_q[LAST][INNER_W-1:0] : '1;
        endcase
      end
    endcase
  end

  // Window 0x6000-0x7FFF: register scaled to 8 KB units, odd last sub-bank
  always_comb begin
    case (grain)
      GR_32K:  win_inner = {bank_q[LAST][W32-1:0], 2'b11};
      GR_16K:  win_inner = {bank_q[LAST][W16-1:0], 1'b1};
      default: win_inner = bank_q[LAST][INNER_W-1:0];
    endcase
  end

  always_comb begin
    win_hit  = win_en && (slot == WIN_SLOT);
    rom_sel  = in_main || win_hit;
    inner    = in_main ? main_inner : win_inner;
    bank_out = rom_sel ? {outer, inner} : '0;
  end
endmodule

// File: rtl/prgmap_top.sv
`timescale 1ns/1ps
module prgmap_top #(
  parameter int NUM_BANK = 4,
  parameter int DATA_W   = 8,
  parameter int ADDR_W   = 16,
  parameter int OUTER_W  = 2,
  parameter int INNER_W  = 6
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]          cpu_addr,
  output logic [OUTER_W+INNER_W-1:0] bank_out,
  output logic                       rom_sel,
  output logic                       win_hit
);
  logic [NUM_BANK-1:0][DATA_W-1:0] bank_q;
  logic [2:0]                      mode;
  logic                            win_en;
  logic [OUTER_W-1:0]              outer;

  prgmap_regs #(
    .NUM_BANK(NUM_BANK), .DATA_W(DATA_W), .ADDR_W(ADDR_W), .OUTER_W(OUTER_W)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .bank_q(bank_q), .mode_q(mode),
    .win_en_q(win_en), .outer_q(outer)
  );

  prgmap_xlate #(
    .NUM_BANK(NUM_BANK), .DATA_W(DATA_W), .ADDR_W(ADDR_W),
    .OUTER_W(OUTER_W), .INNER_W(INNER_W)
  ) u_xlate (
    .cpu_addr(cpu_addr), .bank_q(bank_q), .mode(mode), .win_en(win_en),
    .outer(outer), .bank_out(bank_out), .rom_sel(rom_sel), .win_hit(win_hit)
  );

  // R11: nothing below the window is ever ROM
  a_r11_low_unmapped: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_addr[ADDR_W-1 -: 3] < 3'd3) |-> !rom_sel && (bank_out == '0));

  // R9: window flag only inside 0x6000-0x7FFF
  a_r9_window_range: assert property (@(posedge clk) disable iff (!rst_n)
    win_hit |-> (cpu_addr[ADDR_W-1 -: 3] == 3'd3) && rom_sel);

  // R10: outer block rides above every mapped bank
  a_r10_outer_bits: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel |-> bank_out[OUTER_W+INNER_W-1 -: OUTER_W] == outer);

  // R7: fixed top 8 KB bank in modes 2 and 3
  a_r7_fixed_top: assert property (@(posedge clk) disable iff (!rst_n)
    (mode[2:1] == 2'b01 && cpu_addr[ADDR_W-1 -: 3] == 3'd7)
      |-> bank_out[INNER_W-1:0] == '1);
endmodule

// File: tb/test_prgmap_top.sv
`timescale 1ns/1ps
module test_prgmap_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [7:0]  wr_data;
  logic [15:0] cpu_addr;
  logic [7:0]  bank_out;
  logic        rom_sel, win_hit;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  logic [9:0]  exp_q[$];
  string       tag_q[$];
  logic [15:0] adr_q[$];

  // Reference state kept from the requirements
  logic [7:0] m_bank[4];
  logic [2:0] m_mode;
  logic       m_win;
  logic [1:0] m_outer;

  always #4 clk = ~clk;

  prgmap_top i_prgmap_top (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cpu_addr(cpu_addr), .bank_out(bank_out),
    .rom_sel(rom_sel), .win_hit(win_hit)
  );

  function automatic logic [9:0] model(input logic [15:0] a);
    logic [2:0] s;
    logic [5:0] in6;
    s = a[15:13];
    if (s < 3) return 10'd0;
    if (s == 3) begin
      if (!m_win) return 10'd0;
      case (m_mode[1:0])
        2'd0:    in6 = 6'((m_bank[3] * 4 + 3) & 8'h3F);
        2'd1:    in6 = 6'((m_bank[3] * 2 + 1) & 8'h3F);
        default: in6 = m_bank[3][5:0];
      endcase
      return {1'b1, 1'b1, m_outer, in6};
    end
    case (m_mode[1:0])
      2'd0:    in6 = {(m_mode[2] ? m_bank[3][3:0] : 4'hF), a[14:13]};
      2'd1:    in6 = {(!a[14] ? m_bank[1][4:0] : (m_mode[2] ? m_bank[3][4:0] : 5'h1F)), a[13]};
      default: case (s[1:0])
                 2'd0: in6 = m_bank[0][5:0];
                 2'd1: in6 = m_bank[1][5:0];
                 2'd2: in6 = m_bank[2][5:0];
                 default: in6 = m_mode[2] ? m_bank[3][5:0] : 6'h3F;
               endcase
    endcase
    return {1'b1, 1'b0, m_outer, in6};
  endfunction

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a[15:12] == 4'h8) m_bank[a[1:0]] = d;
    else if (a[15:12] == 4'hD && a[1:0] == 2'd0) begin
      m_mode = d[2:0]; m_win = d[7];
    end else if (a[15:12] == 4'hD && a[1:0] == 2'd3) m_outer = d[2:1];
  endtask

  // Driver: present an address and queue the expected result
  task automatic probe(input logic [15:0] a, input string tag);
    @(negedge clk);
    cpu_addr = a;
    exp_q.push_back(model(a));
    tag_q.push_back(tag);
    adr_q.push_back(a);
  endtask

  // Monitor: compare once the combinational path has settled
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (exp_q.size() > 0) begin
        logic [9:0]  e;
        string       t;
        logic [15:0] a;
        e = exp_q.pop_front(); t = tag_q.pop_front(); a = adr_q.pop_front();
        n_run++;
        if ({rom_sel, win_hit, bank_out} !== e) begin
          n_fail++;
          $display("FAIL %s addr=%h actual rom=%b win=%b bank=%h expected rom=%b win=%b bank=%h",
                   t, a, rom_sel, win_hit, bank_out, e[9], e[8], e[7:0]);
        end
      end
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_bank[i] = 8'hFF;
    m_mode = 3'd0; m_win = 1'b0; m_outer = 2'd0;
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; cpu_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1/R3: reset layout, mode 0 fixed 32 KB bank
    probe(16'h8000, "R1");
    probe(16'hE123, "R1");
    probe(16'hA000, "R3");
    probe(16'h6000, "R11");
    probe(16'h4000, "R11");
    probe(16'h0000, "R11");

    // R4: mode 4
    wr(16'h8003, 8'h05);
    wr(16'hD000, 8'h04);
    probe(16'h8000, "R4");
    probe(16'hE000, "R4");

    // R5: mode 1
    wr(16'h8001, 8'h0A);
    wr(16'hD000, 8'h01);
    probe(16'h8000, "R5");
    probe(16'hA000, "R5");
    probe(16'hC000, "R5");
    probe(16'hE000, "R5");

    // R6: mode 5
    wr(16'hD000, 8'h05);
    probe(16'hC000, "R6");
    probe(16'hE000, "R6");
    probe(16'h8000, "R6");

    // R7: modes 2 and 3
    wr(16'h8000, 8'h11);
    wr(16'h8002, 8'h33);
    wr(16'h8005, 8'h22);
    wr(16'hD000, 8'h02);
    probe(16'h8000, "R7");
    probe(16'hA000, "R7");
    probe(16'hC000, "R7");
    probe(16'hE000, "R7");
    wr(16'hD000, 8'h03);
    probe(16'hE000, "R7");

    // R2: foreign and unused control writes change nothing
    wr(16'h9000, 8'h77);
    wr(16'hD001, 8'hFF);
    wr(16'hD002, 8'hFF);
    probe(16'h8000, "R2");
    probe(16'hE000, "R2");
    probe(16'h6000, "R2");
    wr(16'h8FF4, 8'h2C);
    probe(16'h8000, "R2");

    // R8: modes 6 and 7
    wr(16'hD000, 8'h06);
    probe(16'hE000, "R8");
    wr(16'hD000, 8'h07);
    probe(16'hE000, "R8");
    probe(16'hC000, "R8");

    // R9: window scaling per granularity
    wr(16'hD000, 8'h86);
    probe(16'h6000, "R9");
    probe(16'h7FFF, "R9");
    wr(16'h8003, 8'hFF);
    probe(16'h6000, "R9");
    wr(16'hD000, 8'h80);
    probe(16'h6000, "R9");
    wr(16'h8003, 8'h05);
    probe(16'h6000, "R9");
    wr(16'hD000, 8'h81);
    probe(16'h6000, "R9");
    wr(16'hD000, 8'h01);
    probe(16'h6000, "R11");

    // R10: outer block selection
    wr(16'hD003, 8'h06);
    probe(16'hE000, "R10");
    probe(16'h8000, "R10");
    wr(16'hD003, 8'h02);
    probe(16'hC000, "R10");
    wr(16'hD000, 8'h84);
    wr(16'hD003, 8'h05);
    probe(16'h6000, "R10");
    probe(16'hA000, "R10");
    wr(16'hD003, 8'h01);
    probe(16'hE000, "R10");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule